// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers event pulses from a display controller's main channel (channel 0) and from up to six auxiliary frame-fetch channels (channels 1 to 6). It latches them into two sticky status words and compares them against mask bits taken from two control words. From the set bits that are not masked it drives one level interrupt. When an unmasked channel event arrives it either records that channel's 32-bit frame identifier or, if the interrupt is already high, raises a "subsequent interrupt" flag so that the first identifier is kept.

Channel events arrive one per clock on a single strobe port. Each carries a kind, a channel index, the frame identifier and the channel's frame command word. A few main-only conditions have their own pulse inputs. Software reads the status words and the identifier through a small register port. Writing ones to a status word clears the matching bits.

Event kind encoding on `evtKind`: 0 start-of-frame, 1 end-of-frame, 2 branch status, 3 input underrun, 4 bus error; 5 to 7 are ignored. Register addresses on `regAddr`: 0 main status, 1 auxiliary status, 2 frame identifier (read-only), 3 reads zero.

Top module: `lcd_irq_status`

## Requirements
- R1: After reset the main status, auxiliary status and identifier registers read 0 and `irqOut` is low.
- R2: Start-of-frame and end-of-frame events are recorded only when `evtCmd` bit 22 (start) or bit 21 (end) is set. Channel 0 sets main bits 1 and 8. Channel n from 1 to 6 sets auxiliary bit n-1 or n+7. Events with a channel above 6 change nothing.
- R3: A branch status event sets main bit 9 for channel 0 and auxiliary bit n+15 for channel n.
- R4: An unmasked start, end, branch or bus-error event loads `evtFrameId` into the identifier register when `irqOut` is low at that clock edge.
- R5: When `irqOut` is high at that edge, the same event instead sets main bit 10 and leaves the identifier unchanged.
- R6: A masked event sets only its status bit. The identifier and bit 10 are untouched. Channel-0 masks are `cfgMain` bits 4 (start), 6 (end) and 20 (branch). Channel-n masks are `cfgAux` at the same bit as the auxiliary status bit.
- R7: A bus error sets main bit 2 and writes the channel number into main bits 30:28, whatever the masks. It then follows R4/R5.
- R8: A write to the main status word clears the bits written as one within bits 11:0. Writing one to bit 2 also clears bits 30:28. Bit 12 cannot be cleared by a write.
- R9: A write to the auxiliary status word clears the bits written as one within the mask 0x3E3F3F. All other auxiliary bits are unaffected.
- R10: When `cfgMain` bit 0 goes from 1 to 0 between two clocks, main bit 7 is set.
- R11: `irqOut` is registered and follows, one clock later, the OR of:
  - the auxiliary bits not masked by `cfgAux`;
  - main bits 0, 1, 4, 5, 6, 7, 8, 9, 11, 12, each unless masked by `cfgMain` bits 3, 4, 5, `cfgAux` bit 24, and `cfgMain` bits 21, 11, 6, 20, 23, 24 respectively.

  Main bits 2, 3 and 10 never drive it.
- R12: Pulses on `lastFrameDone`, `acBiasTick`, `outUnderrun`, `readStatusDone` and `cmdDone` set main bits 0, 3, 6, 11 and 12.
- R13: An underrun event sets main bit 4 for channel 0, main bit 5 for channel 1, and auxiliary bit n+23 for channel n from 2 to 6.
- R14: When a clearing write and a setting event hit the same bit in the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Channel event strobe |
| evtKind | input | 3 | Event kind code |
| evtChan | input | 3 | Channel index of the event |
| evtFrameId | input | 32 | Frame identifier of the channel |
| evtCmd | input | 32 | Frame command word of the channel |
| lastFrameDone | input | 1 | Last frame finished pulse |
| acBiasTick | input | 1 | Bias toggle count reached pulse |
| outUnderrun | input | 1 | Output underrun pulse |
| readStatusDone | input | 1 | Panel read status pulse |
| cmdDone | input | 1 | Command interrupt pulse |
| cfgMain | input | 32 | Main control word (enable bit 0 and channel-0 masks) |
| cfgAux | input | 32 | Auxiliary mask word |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Write data (ones clear) |
| regRdData | output | 32 | Read data of the selected register |
| irqOut | output | 1 | Level interrupt |

## Verification
Events are tried on channel 0, on middle auxiliary channels and on an out-of-range channel. This separates the two status words and the bit formulas, and shows that channel 7 is dropped. Each kind is sent with the interrupt low, with the interrupt high, and under a mask. These three cases tell identifier capture from the subsequent flag from status-only recording. Bus errors are sent with every mask set to show that they bypass masking. Clearing writes use all-ones data to expose the bits each word protects, and one write coincides with a setting event.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  typedef enum logic [2:0] {
    EV_SOF      = 3'd0,
    EV_EOF      = 3'd1,
    EV_BRANCH   = 3'd2,
    EV_UNDERRUN = 3'd3,
    EV_BUSERR   = 3'd4
  } evKind_e;

  localparam int STAT_W      = 32;
  localparam int MAIN_SET_W  = 13;
  localparam int CMD_SOF_BIT = 22;
  localparam int CMD_EOF_BIT = 21;
  localparam int EOF_OFS     = 7;
  localparam int BS_OFS      = 15;
  localparam int IU_OFS      = 23;
  localparam logic [STAT_W-1:0] MAIN_CLR_MASK = 32'h0000_0FFF;
  localparam logic [STAT_W-1:0] AUX_CLR_MASK  = 32'h003E_3F3F;

  typedef struct packed {
    logic [MAIN_SET_W-1:0] mainSet;
    logic [STAT_W-1:0]     auxSet;
    logic                  berLoad;
    logic                  idLoad;
  } stb_t;
endpackage

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
  import lcd_irq_pkg::*;
#(
  parameter int NUM_AUX = 6,
  parameter int CH_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [2:0]       evtKind,
  input  logic [CH_W-1:0]  evtChan,
  input  logic [31:0]      evtCmd,
  input  logic             lastFrameDone,
  input  logic             acBiasTick,
  input  logic             outUnderrun,
  input  logic             readStatusDone,
  input  logic             cmdDone,
  input  logic [31:0]      cfgMain,
  input  logic [31:0]      cfgAux,
  input  logic             irqOut,
  output stb_t             stb
);
  logic       prevEnable;
  logic [4:0] chPos;
  logic       chanOk;
  logic       isMain;
  logic       fireRule;
  logic       unusedBits;

  assign unusedBits = ^{evtCmd[31:23], evtCmd[20:0], cfgMain[31:21], cfgMain[19:7],
                        cfgMain[5], cfgMain[3:1]};
  assign chPos  = 5'(evtChan);
  assign chanOk = (int'(evtChan) <= NUM_AUX);
  assign isMain = (evtChan == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEnable <= 1'b0;
    else       prevEnable <= cfgMain[0];
  end

  always_comb begin
    stb      = '0;
    fireRule = 1'b0;
    if (evtValid && chanOk) begin
      unique case (evKind_e'(evtKind))
        EV_SOF: if (evtCmd[CMD_SOF_BIT]) begin
          if (isMain) begin
            stb.mainSet[1] = 1'b1;
            fireRule = !cfgMain[4];
          end else begin
            stb.auxSet[chPos - 5'd1] = 1'b1;
            fireRule = !cfgAux[chPos - 5'd1];
          end
        end
        EV_EOF: if (evtCmd[CMD_EOF_BIT]) begin
          if (isMain) begin
            stb.mainSet[8] = 1'b1;
            fireRule = !cfgMain[6];
          end else begin
            stb.auxSet[chPos + 5'(EOF_OFS)] = 1'b1;
            fireRule = !cfgAux[chPos + 5'(EOF_OFS)];
          end
        end
        EV_BRANCH: begin
          if (isMain) begin
            stb.mainSet[9] = 1'b1;
            fireRule = !cfgMain[20];
          end else begin
            stb.auxSet[chPos + 5'(BS_OFS)] = 1'b1;
            fireRule = !cfgAux[chPos + 5'(BS_OFS)];
          end
        end
        EV_UNDERRUN: begin
          if (isMain)              stb.mainSet[4] = 1'b1;
          else if (chPos == 5'd1)  stb.mainSet[5] = 1'b1;
          else                     stb.auxSet[chPos + 5'(IU_OFS)] = 1'b1;
        end
        EV_BUSERR: begin
          stb.mainSet[2] = 1'b1;
          stb.berLoad    = 1'b1;
          fireRule       = 1'b1;
        end
        default: ;
      endcase
    end
    if (fireRule) begin
      if (irqOut) stb.mainSet[10] = 1'b1;
      else        stb.idLoad      = 1'b1;
    end
    stb.mainSet[0]  = stb.mainSet[0]  | lastFrameDone;
    stb.mainSet[3]  = stb.mainSet[3]  | acBiasTick;
    stb.mainSet[6]  = stb.mainSet[6]  | outUnderrun;
    stb.mainSet[7]  = stb.mainSet[7]  | (prevEnable & ~cfgMain[0]);
    stb.mainSet[11] = stb.mainSet[11] | readStatusDone;
    stb.mainSet[12] = stb.mainSet[12] | cmdDone;
  end
endmodule

// File: rtl/lcd_irq_dp.sv
module lcd_irq_dp
  import lcd_irq_pkg::*;
#(
  parameter int ID_W = 32,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [CH_W-1:0]   evtChan,
  input  logic [ID_W-1:0]   evtFrameId,
  input  logic [31:0]       cfgMain,
  input  logic [31:0]       cfgAux,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       mainStat,
  output logic [31:0]       auxStat,
  output logic [ID_W-1:0]   idReg,
  output logic              irqOut,
  output logic [31:0]       regRdData
);
  logic [31:0] mainNext;
  logic [31:0] auxNext;
  logic [31:0] mainEn;
  logic        irqNext;
  logic        unusedCfg;

  assign unusedCfg = ^{cfgMain[31:25], cfgMain[22], cfgMain[19:12], cfgMain[10:7],
                       cfgMain[2:0], cfgAux[31:25], cfgAux[23:0]};

  always_comb begin
    mainNext = mainStat;
    auxNext  = auxStat;
    if (regWrEn && regAddr == 2'd0) begin
      mainNext = mainNext & ~(regWrData & MAIN_CLR_MASK);
      if (regWrData[2]) mainNext[30:28] = 3'd0;
    end
    if (regWrEn && regAddr == 2'd1)
      auxNext = auxNext & ~(regWrData & AUX_CLR_MASK);
    mainNext = mainNext | 32'(stb.mainSet);
    if (stb.berLoad) mainNext[30:28] = 3'(evtChan);
    auxNext = auxNext | stb.auxSet;
  end

  always_comb begin
    mainEn     = '0;
    mainEn[0]  = !cfgMain[3];
    mainEn[1]  = !cfgMain[4];
    mainEn[4]  = !cfgMain[5];
    mainEn[5]  = !cfgAux[24];
    mainEn[6]  = !cfgMain[21];
    mainEn[7]  = !cfgMain[11];
    mainEn[8]  = !cfgMain[6];
    mainEn[9]  = !cfgMain[20];
    mainEn[11] = !cfgMain[23];
    mainEn[12] = !cfgMain[24];
    irqNext = |(mainStat & mainEn) | |(auxStat & ~cfgAux);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainStat <= '0;
      auxStat  <= '0;
      idReg    <= '0;
      irqOut   <= 1'b0;
    end else begin
      mainStat <= mainNext;
      auxStat  <= auxNext;
      irqOut   <= irqNext;
      if (stb.idLoad) idReg <= evtFrameId;
    end
  end

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdData = mainStat;
      2'd1:    regRdData = auxStat;
      2'd2:    regRdData = 32'(idReg);
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status
  import lcd_irq_pkg::*;
#(
  parameter int NUM_AUX = 6,
  parameter int ID_W    = 32,
  parameter int CH_W    = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtValid,
  input  logic [2:0]      evtKind,
  input  logic [2:0]      evtChan,
  input  logic [31:0]     evtFrameId,
  input  logic [31:0]     evtCmd,
  input  logic            lastFrameDone,
  input  logic            acBiasTick,
  input  logic            outUnderrun,
  input  logic            readStatusDone,
  input  logic            cmdDone,
  input  logic [31:0]     cfgMain,
  input  logic [31:0]     cfgAux,
  input  logic            regWrEn,
  input  logic [1:0]      regAddr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  output logic            irqOut
);
  stb_t            stb;
  logic [31:0]     mainStat;
  logic [31:0]     auxStat;
  logic [ID_W-1:0] idReg;

  lcd_irq_ctrl #(.NUM_AUX(NUM_AUX), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .evtChan(CH_W'(evtChan)), .evtCmd(evtCmd), .lastFrameDone(lastFrameDone),
    .acBiasTick(acBiasTick), .outUnderrun(outUnderrun),
    .readStatusDone(readStatusDone), .cmdDone(cmdDone), .cfgMain(cfgMain),
    .cfgAux(cfgAux), .irqOut(irqOut), .stb(stb)
  );

  lcd_irq_dp #(.ID_W(ID_W), .CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evtChan(CH_W'(evtChan)),
    .evtFrameId(ID_W'(evtFrameId)), .cfgMain(cfgMain), .cfgAux(cfgAux),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .mainStat(mainStat), .auxStat(auxStat), .idReg(idReg), .irqOut(irqOut),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/lcd_irq_status_chk.sv
module lcd_irq_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        evtValid,
  input logic [2:0]  evtKind,
  input logic [2:0]  evtChan,
  input logic        lastFrameDone,
  input logic [31:0] cfgMain,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] mainStat,
  input logic [31:0] auxStat,
  input logic [31:0] idReg,
  input logic        irqOut
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> $stable(idReg)); // R5
  AST_BER_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == 3'd4 && evtChan <= 3'd6) |=>
      (mainStat[2] && mainStat[30:28] == $past(evtChan))); // R7
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (mainStat == 32'd0 && auxStat == 32'd0) |=> !irqOut); // R11
  AST_QD_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(cfgMain[0]) && !cfgMain[0]) |=> mainStat[7]); // R10
  AST_CLEAR_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && regWrData[0] && !lastFrameDone) |=> !mainStat[0]); // R8
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    auxStat[26] |=> auxStat[26]); // R9
endmodule

bind lcd_irq_status lcd_irq_status_chk u_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
  .evtChan(evtChan), .lastFrameDone(lastFrameDone), .cfgMain(cfgMain),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .mainStat(mainStat), .auxStat(auxStat), .idReg(idReg), .irqOut(irqOut)
);

// File: tb/sim_lcd_irq_status.sv
`timescale 1ns/1ps
module sim_lcd_irq_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [2:0]  evtKind = '0;
  logic [2:0]  evtChan = '0;
  logic [31:0] evtFrameId = '0;
  logic [31:0] evtCmd = '0;
  logic        lastFrameDone = 1'b0;
  logic        acBiasTick = 1'b0;
  logic        outUnderrun = 1'b0;
  logic        readStatusDone = 1'b0;
  logic        cmdDone = 1'b0;
  logic [31:0] cfgMain = '0;
  logic [31:0] cfgAux = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails = 0;

  localparam logic [31:0] SOF_CMD = 32'h0040_0000;
  localparam logic [31:0] EOF_CMD = 32'h0020_0000;

  always #5 clk = ~clk;

  lcd_irq_status u0 (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .evtChan(evtChan), .evtFrameId(evtFrameId), .evtCmd(evtCmd),
    .lastFrameDone(lastFrameDone), .acBiasTick(acBiasTick),
    .outUnderrun(outUnderrun), .readStatusDone(readStatusDone),
    .cmdDone(cmdDone), .cfgMain(cfgMain), .cfgAux(cfgAux),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic checkReg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    check(tag, v, exp);
  endtask

  task automatic fireEvt(input logic [2:0] k, input logic [2:0] ch,
                         input logic [31:0] id, input logic [31:0] cmd);
    evtValid = 1'b1; evtKind = k; evtChan = ch; evtFrameId = id; evtCmd = cmd;
    tick();
    evtValid = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic doReset();
    cfgMain = '0; cfgAux = '0;
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic clearAll();
    regWrite(2'd0, 32'hFFFF_FFFF);
    regWrite(2'd1, 32'hFFFF_FFFF);
    tick(); tick();
  endtask

  task automatic testReset();
    checkReg("R1 main after reset", 2'd0, 32'h0);
    checkReg("R1 aux after reset", 2'd1, 32'h0);
    checkReg("R1 id after reset", 2'd2, 32'h0);
    check("R1 irq after reset", 32'(irqOut), 32'h0);
  endtask

  task automatic testFirstEvent();
    fireEvt(3'd0, 3'd0, 32'hA0A0_0001, SOF_CMD);
    checkReg("R2 sof ch0 bit1", 2'd0, 32'h0000_0002);
    checkReg("R4 id captured", 2'd2, 32'hA0A0_0001);
    check("R11 irq not yet", 32'(irqOut), 32'h0);
    tick();
    check("R11 irq one clock later", 32'(irqOut), 32'h1);
    regWrite(2'd0, 32'h2);
    checkReg("R8 bit1 cleared", 2'd0, 32'h0);
    tick();
    check("R11 irq drops after clear", 32'(irqOut), 32'h0);
  endtask

  task automatic testGatingAndSubsequent();
    fireEvt(3'd0, 3'd3, 32'h31, 32'h0);
    checkReg("R2 sof gated off aux", 2'd1, 32'h0);
    fireEvt(3'd0, 3'd7, 32'h32, SOF_CMD);
    checkReg("R2 channel 7 ignored aux", 2'd1, 32'h0);
    checkReg("R2 channel 7 ignored id", 2'd2, 32'hA0A0_0001);
    fireEvt(3'd0, 3'd3, 32'h33, SOF_CMD);
    tick();
    fireEvt(3'd1, 3'd3, 32'h34, EOF_CMD);
    checkReg("R2 aux sof/eof ch3", 2'd1, 32'h0000_0404);
    checkReg("R5 subsequent flag", 2'd0, 32'h0000_0400);
    checkReg("R5 id kept", 2'd2, 32'h33);
    clearAll();
    check("R11 irq low after clear", 32'(irqOut), 32'h0);
  endtask

  task automatic testMasked();
    cfgAux = 32'h0002_0000;
    fireEvt(3'd2, 3'd2, 32'h55, 32'h0);
    checkReg("R3 branch ch2 aux bit17", 2'd1, 32'h0002_0000);
    checkReg("R6 no subsequent flag", 2'd0, 32'h0);
    checkReg("R6 id untouched", 2'd2, 32'h33);
    tick();
    check("R6 irq stays low", 32'(irqOut), 32'h0);
    fireEvt(3'd2, 3'd0, 32'h66, 32'h0);
    checkReg("R3 branch ch0 bit9", 2'd0, 32'h0000_0200);
    checkReg("R4 id from branch", 2'd2, 32'h66);
    cfgAux = 32'h0;
    clearAll();
  endtask

  task automatic testBusError();
    cfgMain = 32'h01B0_0878;
    cfgAux  = 32'hFFFF_FFFF;
    tick();
    fireEvt(3'd4, 3'd5, 32'h77, 32'h0);
    checkReg("R7 bus error bits", 2'd0, 32'h5000_0004);
    checkReg("R7 id from bus error", 2'd2, 32'h77);
    tick();
    check("R11 bus error does not drive irq", 32'(irqOut), 32'h0);
    regWrite(2'd0, 32'h4);
    checkReg("R8 bit2 clears channel field", 2'd0, 32'h0);
    cfgMain = '0; cfgAux = '0;
    tick();
  endtask

  task automatic testUnderrunAndQd();
    fireEvt(3'd3, 3'd0, 32'h1, 32'h0);
    fireEvt(3'd3, 3'd1, 32'h2, 32'h0);
    checkReg("R13 underrun ch0/ch1 main", 2'd0, 32'h0000_0030);
    clearAll();
    cfgMain = 32'h1;
    tick();
    checkReg("R10 enable rise sets nothing", 2'd0, 32'h0);
    cfgMain = 32'h0;
    tick();
    checkReg("R10 quick disable bit7", 2'd0, 32'h0000_0080);
    clearAll();
  endtask

  task automatic testSetWins();
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h2;
    evtValid = 1'b1; evtKind = 3'd0; evtChan = 3'd0; evtFrameId = 32'h88; evtCmd = SOF_CMD;
    tick();
    regWrEn = 1'b0; evtValid = 1'b0;
    checkReg("R14 set wins over clear", 2'd0, 32'h0000_0002);
    clearAll();
  endtask

  task automatic testAuxClear();
    fireEvt(3'd0, 3'd1, 32'h91, SOF_CMD);
    fireEvt(3'd2, 3'd1, 32'h92, 32'h0);
    fireEvt(3'd3, 3'd3, 32'h93, 32'h0);
    checkReg("R13 aux bits set", 2'd1, 32'h0401_0001);
    regWrite(2'd1, 32'hFFFF_FFFF);
    checkReg("R9 aux clear mask", 2'd1, 32'h0401_0000);
  endtask

  task automatic testPulses();
    lastFrameDone = 1'b1; acBiasTick = 1'b1; outUnderrun = 1'b1;
    readStatusDone = 1'b1; cmdDone = 1'b1;
    tick();
    lastFrameDone = 1'b0; acBiasTick = 1'b0; outUnderrun = 1'b0;
    readStatusDone = 1'b0; cmdDone = 1'b0;
    checkReg("R12 pulse bits", 2'd0, 32'h0000_1849);
    regWrite(2'd0, 32'hFFFF_FFFF);
    checkReg("R8 bit12 survives clear", 2'd0, 32'h0000_1000);
    tick();
    check("R11 bit12 drives irq", 32'(irqOut), 32'h1);
    cfgMain = 32'h0100_0000;
    tick();
    check("R11 mask drops irq", 32'(irqOut), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testFirstEvent();
    testGatingAndSubsequent();
    testMasked();
    testBusError();
    testUnderrunAndQd();
    testSetWins();
    testAuxClear();
    doReset();
    testPulses();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule